// File: doc/BRIEF.md
# Multi-view video memory aperture

This block sits between a bus and a byte-wide video RAM. It shows the same RAM through four aliased windows, and bits 25:24 of a 26-bit aperture address choose the window. The packed window maps aperture bytes directly onto RAM bytes. The color window is the same mapping, except that writes to the first byte of each 32-bit pixel (the alpha/extra byte) are dropped. The two plane windows spread the address by shift-and-merge, so that one byte plane of every pixel appears as a dense array. The 2-plane window serves 16-bit pixels and the 4-plane window serves 32-bit pixels. Inside a packed pixel the bytes are ordered alpha/extra, blue, green, red.

A request carries a size of byte, halfword or word. The block breaks it into one RAM byte operation per clock and assembles read data big-endian. Requests arrive on a valid/ready channel. `req_ready` is high only while the block is idle, so a new request waits until the previous response has been taken. Responses leave on a second valid/ready channel. Once `rsp_valid` rises, it and `rsp_rdata` hold unchanged until `rsp_ready` is seen high at a clock edge. The RAM has 2^RAM_AW bytes (2 KiB by default), and every physical address is reduced modulo that size.

Top module: `vmem_view_xlat`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Packed window (addr[25:24]=0): byte i of a word access (i=0..3) is RAM byte (addr+i) mod size and sits in `rsp_rdata[31-8i -: 8]`. A word write stores `req_wdata[31-8i -: 8]` to that byte.
- R3: Color window (addr[25:24]=1): reads match the packed window. A write skips every byte whose physical address has bits 1:0 equal to 0, so an aligned word write changes only bytes +1, +2 and +3.
- R4: 2-plane window (addr[25:24]=2): the base physical byte is ((addr<<1) mod size) + addr[23]. A word access touches base+0, +2, +4 and +6, with the first of these in bits 31:24.
- R5: 4-plane window (addr[25:24]=3): the base physical byte is ((addr<<2) mod size) + addr[23:22]. A word access touches base+0, +4, +8 and +12, with the first of these in bits 31:24.
- R6: A halfword (req_size=1) is made of two byte accesses. The first is at aperture address addr and the second at addr+1, and each is mapped with the window of its own address. The first byte lands in `rsp_rdata[15:8]`, the second in [7:0], and bits 31:16 read 0. A write takes its bytes from `req_wdata[15:8]` and then [7:0].
- R7: A byte access (req_size=0) returns its byte in `rsp_rdata[7:0]` with bits 31:8 zero, and a byte write stores `req_wdata[7:0]`. A size code of 3 behaves as a word.
- R8: `req_ready` is 0 while a response is pending. `rsp_valid` and `rsp_rdata` hold stable under back-pressure until `rsp_ready` is sampled high, and after that edge the block is idle again.
- R9: For an access of n bytes, `rsp_valid` rises on the (n+1)th rising edge after the edge that accepted the request.
- R10: Physical addresses wrap modulo the RAM size. This covers aperture addresses above the RAM size and the beat offsets of a word that crosses the top of the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 26 | Aperture address; bits 25:24 pick the window |
| req_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| rsp_valid | output | 1 | Response present (read data or write completion) |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Big-endian read data, 0 for writes |

## Verification
The color window's write blocking and its unrestricted read path act on the same RAM bytes. A word written through the color window is therefore read back through the packed window, and the result must hold the old alpha byte beside three new color bytes. Response back-pressure and request acceptance also interact at one edge. The bench holds `rsp_ready` low for random spans, checks that the data does not move and that no request is taken, and then checks that the block is idle on the cycle right after the response leaves. Random mixes of window, size and address, including halfwords that cross a window boundary, are compared against a shadow byte array kept in the bench.

// File: rtl/vview_pkg.sv
package vview_pkg;
  localparam int unsigned APER_W = 26;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

  localparam logic [1:0] VIEW_PACKED = 2'd0;
  localparam logic [1:0] VIEW_COLOR  = 2'd1;
  localparam logic [1:0] VIEW_PLANE2 = 2'd2;
  localparam logic [1:0] VIEW_PLANE4 = 2'd3;
endpackage

// File: rtl/vview_addr_map.sv
module vview_addr_map
  import vview_pkg::*;
#(
  parameter int unsigned RAM_AW = 11
) (
  input  logic [APER_W-1:0] base_addr,
  input  logic [1:0]        beat,
  input  logic              word_mode,
  output logic [RAM_AW-1:0] phys,
  output logic [1:0]        view
);
  logic [APER_W-1:0] eff;
  logic [RAM_AW-1:0] root;
  logic [RAM_AW-1:0] step;

  // words keep one window and stride; byte/half beats remap addr+k
  always_comb begin
    eff  = word_mode ? base_addr : base_addr + APER_W'(beat);
    view = eff[25:24];
    case (view)
      VIEW_PLANE2: begin
        root = {eff[RAM_AW-2:0], eff[23]};
        step = RAM_AW'({beat, 1'b0});
      end
      VIEW_PLANE4: begin
        root = {eff[RAM_AW-3:0], eff[23:22]};
        step = RAM_AW'({beat, 2'b00});
      end
      default: begin
        root = eff[RAM_AW-1:0];
        step = RAM_AW'(beat);
      end
    endcase
    phys = root + (word_mode ? step : '0);
  end
endmodule

// File: rtl/vview_byte_ram.sv
module vview_byte_ram #(
  parameter int unsigned RAM_AW = 11
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int unsigned DEPTH = 1 << RAM_AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[addr] <= wdata;
      else    rdata       <= cells[addr];
    end
  end
endmodule

// File: rtl/vmem_view_xlat.sv
module vmem_view_xlat
  import vview_pkg::*;
#(
  parameter int unsigned RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [APER_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata
);
  seq_state_e        state;
  logic [APER_W-1:0] a_addr;
  logic              a_write;
  logic              a_word;
  logic [31:0]       a_wdata;
  logic [1:0]        beat;
  logic [1:0]        last_beat;
  logic [31:0]       acc;
  logic              cap;
  logic [2:0]        lat_cnt;

  logic              accept;
  logic [RAM_AW-1:0] ram_addr;
  logic [1:0]        map_view;
  logic              ram_en;
  logic              ram_we;
  logic [7:0]        ram_wbyte;
  logic [7:0]        ram_rbyte;
  logic [1:0]        lane;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = acc;
  assign accept    = req_ready && req_valid;

  vview_addr_map #(.RAM_AW(RAM_AW)) i_map (
    .base_addr (a_addr),
    .beat      (beat),
    .word_mode (a_word),
    .phys      (ram_addr),
    .view      (map_view)
  );

  // byte lane counted from the top of the request's data
  always_comb begin
    lane   = last_beat - beat;
    ram_en = (state == ST_BEAT);
    ram_we = ram_en && a_write &&
             !(map_view == VIEW_COLOR && ram_addr[1:0] == 2'b00);
    case (lane)
      2'd0:    ram_wbyte = a_wdata[7:0];
      2'd1:    ram_wbyte = a_wdata[15:8];
      2'd2:    ram_wbyte = a_wdata[23:16];
      default: ram_wbyte = a_wdata[31:24];
    endcase
  end

  vview_byte_ram #(.RAM_AW(RAM_AW)) i_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wbyte),
    .rdata (ram_rbyte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      a_addr    <= '0;
      a_write   <= 1'b0;
      a_word    <= 1'b0;
      a_wdata   <= '0;
      beat      <= '0;
      last_beat <= '0;
      acc       <= '0;
      cap       <= 1'b0;
      lat_cnt   <= '0;
    end else begin
      if (cap) acc <= {acc[23:0], ram_rbyte};
      case (state)
        ST_IDLE: begin
          if (accept) begin
            a_addr    <= req_addr;
            a_write   <= req_write;
            a_wdata   <= req_wdata;
            a_word    <= req_size[1];
            last_beat <= req_size[1] ? 2'd3 : {1'b0, req_size[0]};
            beat      <= '0;
            acc       <= '0;
            cap       <= 1'b0;
            lat_cnt   <= '0;
            state     <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          beat    <= beat + 2'd1;
          cap     <= !a_write;
          lat_cnt <= lat_cnt + 3'd1;
          if (beat == last_beat) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          cap     <= 1'b0;
          lat_cnt <= lat_cnt + 3'd1;
          state   <= ST_RESP;
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R8: no acceptance while a response is waiting
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8: response held under back-pressure
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9: response appears n+1 edges after acceptance
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (lat_cnt == 3'(last_beat) + 3'd2));

  // R4: 2-plane word beats step by two bytes
  assert_plane2_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && a_word && beat != 2'd0 && map_view == VIEW_PLANE2)
      |-> (ram_addr == $past(ram_addr) + RAM_AW'(2)));

  // R5: 4-plane word beats step by four bytes
  assert_plane4_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && a_word && beat != 2'd0 && map_view == VIEW_PLANE4)
      |-> (ram_addr == $past(ram_addr) + RAM_AW'(4)));
endmodule

// File: tb/test_vmem_view_xlat.sv
module test_vmem_view_xlat;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned RAM_AW     = 11;
  localparam int unsigned RAM_SIZE   = 1 << RAM_AW;
  localparam int unsigned MASK       = RAM_SIZE - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;
  logic [7:0]  shadow [RAM_SIZE];

  always #(CLK_PERIOD/2) clk = ~clk;

  vmem_view_xlat #(.RAM_AW(RAM_AW)) i_vmem_view_xlat (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic int unsigned map_one(input logic [25:0] a);
    int unsigned v = a;
    case (a[25:24])
      2'd2:    return ((v * 2) & MASK) + a[23];
      2'd3:    return ((v * 4) & MASK) + a[23:22];
      default: return v & MASK;
    endcase
  endfunction

  function automatic int unsigned nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int unsigned beat_phys(input logic [1:0] sz, input logic [25:0] a, input int unsigned k);
    int unsigned stride;
    if (sz[1]) begin
      stride = (a[25:24] == 2'd2) ? 2 : (a[25:24] == 2'd3) ? 4 : 1;
      return (map_one(a) + k * stride) & MASK;
    end
    return map_one(a + 26'(k));
  endfunction

  function automatic logic [1:0] beat_view(input logic [1:0] sz, input logic [25:0] a, input int unsigned k);
    logic [25:0] e = sz[1] ? a : a + 26'(k);
    return e[25:24];
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] sz, input logic [25:0] a);
    logic [31:0] r = '0;
    for (int k = 0; k < int'(nbytes(sz)); k++)
      r = {r[23:0], shadow[beat_phys(sz, a, k)]};
    return r;
  endfunction

  task automatic model_write(input logic [1:0] sz, input logic [25:0] a, input logic [31:0] d);
    int unsigned n = nbytes(sz);
    for (int k = 0; k < int'(n); k++) begin
      int unsigned p = beat_phys(sz, a, k);
      if (!(beat_view(sz, a, k) == 2'd1 && (p & 3) == 0))
        shadow[p] = d[8*(n-1-k) +: 8];
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [25:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    int unsigned n = nbytes(sz);
    int cyc;
    int hold;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 busy ready", {31'd0, req_ready}, 32'd0);
    cyc = 1;
    while (!rsp_valid && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    // R9: edge count after accept = cyc-1 = n+1
    chk(cyc == int'(n) + 2, "R9 latency", 32'(cyc), 32'(n + 2));
    rd = rsp_rdata;
    hold = $urandom_range(0, 3);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_rdata == rd, "R8 hold", rsp_rdata, rd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8 release", {30'd0, rsp_valid, req_ready}, 32'd1);
    if (wr) model_write(sz, a, wd);
  endtask

  task automatic rd_check(input logic [1:0] sz, input logic [25:0] a, input string req);
    logic [31:0] got;
    logic [31:0] exp;
    exp = model_read(sz, a);
    access(1'b0, sz, a, 32'd0, got);
    chk(got === exp, req, got, exp);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [25:0] a, input logic [31:0] d);
    logic [31:0] junk;
    access(1'b1, sz, a, d, junk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset",
        {30'd0, req_ready, rsp_valid}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);

    // fill RAM through packed window (R2)
    for (int i = 0; i < int'(RAM_SIZE / 4); i++) wr(2'd2, 26'(4 * i), $urandom);

    // R2: packed word, big-endian
    wr(2'd2, 26'h0000100, 32'h11223344);
    rd_check(2'd2, 26'h0000100, "R2 packed word");
    chk(shadow[32'h100] == 8'h11, "R2 first byte", 32'(shadow[32'h100]), 32'h11);
    // R7: byte read lands low
    rd_check(2'd0, 26'h0000100, "R7 byte 0");
    rd_check(2'd0, 26'h0000103, "R7 byte 3");
    access(1'b0, 2'd0, 26'h0000102, 32'd0, got);
    chk(got == 32'h00000033, "R7 byte value", got, 32'h33);
    wr(2'd0, 26'h0000101, 32'hFFFFFF5A);
    rd_check(2'd2, 26'h0000100, "R7 byte write");
    rd_check(2'd3, 26'h0000100, "R7 size 3 as word");

    // R3: color window blocks alpha byte
    wr(2'd2, 26'h1000100, 32'hAABBCCDD);
    access(1'b0, 2'd2, 26'h0000100, 32'd0, got);
    chk(got == 32'h11BBCCDD, "R3 alpha kept", got, 32'h11BBCCDD);
    rd_check(2'd2, 26'h1000100, "R3 color read");
    wr(2'd0, 26'h1000104, 32'h000000EE);
    rd_check(2'd2, 26'h0000104, "R3 byte blocked");

    // R4: 2-plane window
    rd_check(2'd2, 26'h2000040, "R4 plane0 word");
    rd_check(2'd2, 26'h2800040, "R4 plane1 word");
    wr(2'd2, 26'h2800010, 32'h01020304);
    access(1'b0, 2'd0, 26'h0000021, 32'd0, got);
    chk(got == 32'h01, "R4 scatter +0", got, 32'h01);
    access(1'b0, 2'd0, 26'h0000027, 32'd0, got);
    chk(got == 32'h04, "R4 scatter +6", got, 32'h04);

    // R5: 4-plane window
    wr(2'd2, 26'h3C00010, 32'hA1B2C3D4);
    access(1'b0, 2'd0, 26'h0000043, 32'd0, got);
    chk(got == 32'hA1, "R5 scatter +0", got, 32'hA1);
    access(1'b0, 2'd0, 26'h000004F, 32'd0, got);
    chk(got == 32'hD4, "R5 scatter +12", got, 32'hD4);
    rd_check(2'd2, 26'h3400008, "R5 plane1 word");

    // R6: halfwords incl. window-crossing
    wr(2'd1, 26'h0000200, 32'h0000BEEF);
    access(1'b0, 2'd1, 26'h0000200, 32'd0, got);
    chk(got == 32'h0000BEEF, "R6 half", got, 32'h0000BEEF);
    rd_check(2'd1, 26'h2FFFFFF, "R6 half crosses window");
    wr(2'd1, 26'h0FFFFFF, 32'h00001234);
    rd_check(2'd1, 26'h0FFFFFF, "R6 half into color window");

    // R10: wrap
    rd_check(2'd2, 26'h0000800, "R10 alias");
    wr(2'd2, 26'h00007FE, 32'hCAFEF00D);
    access(1'b0, 2'd0, 26'h0000001, 32'd0, got);
    chk(got == 32'h0D, "R10 wrap beat", got, 32'h0D);
    rd_check(2'd2, 26'h3FFFFFC, "R10 plane wrap");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0]  sz = 2'($urandom_range(0, 3));
      logic [25:0] a  = 26'($urandom);
      if ($urandom_range(0, 1) == 1) wr(sz, a, $urandom);
      else rd_check(sz, a, "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule